// File: doc/BRIEF.md
# Multi-Output Interrupt Routing Controller

This block collects a set of external interrupt request lines and steers them onto a small number of processor interrupt outputs. Each source line is first passed through a two-flop synchroniser. It is then qualified by its own trigger settings: edge or level detection, and active-high or active-low sense. The qualified result sets a per-source pending bit. Sources are grouped into 16-bit words. Each output has its own enable mask per word, so any source can drive any subset of the outputs.

Software reaches the controller through a simple synchronous register port. The port carries a byte address, 16-bit write data, and read data that is registered one cycle after the access. Software can always read the pending state, even for sources that are masked on every output. Masking a source does not discard its pending state. The interrupt is delivered as soon as an output enables the source again, unless software clears it first.

Top module: `irq_route_ctrl`

## Requirements
- R1: Register map, per word w (byte offsets). Pending status is at 0x00 + 0x40*w. Clear is at 0x10 + 0x40*w. Edge-select is at 0x20 + 0x40*w. Polarity is at 0x30 + 0x40*w. The enable for word w and output n is at 0x100 + 0x10*w + 0x20*n. Source k sits in word k/16, bit k%16. Edge, polarity and enable registers read back the value last written. Read data appears on the clock after the read access.
- R2: A read from any address outside the map returns 0. Writes to a status register have no effect.
- R3: While reset is held low, every output and the read data are 0. After reset, the edge, polarity, enable and pending bits are all 0.
- R4: Level mode (edge bit 0): the pending bit follows the qualified input, three clocks after the raw input changes. A clear has no lasting effect in this mode. With the default polarity 0, a low input counts as active.
- R5: Edge mode (edge bit 1) latches pending on a rising edge when the polarity bit is 1, and on a falling edge when it is 0. An edge of the other direction does not set pending.
- R6: Writing 1 to a clear bit drops that source's pending bit. Writing 0 has no effect.
- R7: If a qualifying edge arrives in the same cycle as a clear of that source, the pending bit stays set.
- R8: Output n is high one clock after any source is both pending and enabled for output n. A source enabled for several outputs drives all of them. An output whose enabled sources are all not pending is low.
- R9: Masking a source keeps its pending bit, and software can still read it. Enabling the source again delivers the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | 32 | Raw interrupt request lines, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the clock after a read |
| cpu_irq | output | 4 | Processor interrupt outputs, active high |

## Verification
The bench builds the block with its default parameters: two 16-bit words, four outputs and a 9-bit address. With these values the highest enable register (word 1, output 3, at 0x170) is in use, and so are the cross-word cases where a word-1 source fans out to outputs 0 and 3 together. The exact synchroniser-to-output latency is measured edge by edge. A clear write is placed in the very cycle a new edge is detected, to check which one wins.

// File: rtl/irqr_pkg.sv
// Package: shared register kinds and the address decoder for the routing controller.
// Assumes 16-bit registers on 0x10-aligned byte offsets.
package irqr_pkg;

    typedef enum logic [2:0] {
        RK_NONE, RK_STATUS, RK_CLEAR, RK_EDGE, RK_POL, RK_EN
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e kind;
        int        word;
        int        out;
    } reg_dec_t;

    // Map a byte address onto a register kind plus its word and output indices.
    function automatic reg_dec_t decode_addr(logic [15:0] a, int nwords, int nout);
        reg_dec_t d;
        int idx;
        d.kind = RK_NONE;
        d.word = 0;
        d.out  = 0;
        if (a[3:0] == 4'h0) begin
            if (a < 16'h0100) begin
                if (int'(a[15:6]) < nwords) begin
                    d.word = int'(a[15:6]);
                    case (a[5:4])
                        2'd0:    d.kind = RK_STATUS;
                        2'd1:    d.kind = RK_CLEAR;
                        2'd2:    d.kind = RK_EDGE;
                        default: d.kind = RK_POL;
                    endcase
                end
            end else begin
                idx = int'(a[15:4]) - 16;
                if (idx < nwords * nout) begin
                    d.kind = RK_EN;
                    d.word = idx % nwords;
                    d.out  = idx / nwords;
                end
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/irqr_sync_detect.sv
// Source front end: two-flop synchroniser, polarity qualification and a
// pending latch per source. Assumes clr is a one-cycle pulse from a write.
module irqr_sync_detect #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] edge_sel,
    input  logic [NSRC-1:0] pol_sel,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pending
);

    logic [NSRC-1:0] sync1, sync2, prev;
    logic [NSRC-1:0] qual, qual_prev, rise;

    // Synchronise the raw lines and keep the previous synchronised sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
        end else begin
            sync1 <= src;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    // Qualify by polarity; an active transition is a new qualified assertion.
    always_comb begin
        qual      = sync2 ~^ pol_sel;
        qual_prev = prev ~^ pol_sel;
        rise      = qual & ~qual_prev;
    end

    // Pending latch: edge mode sets on rise and drops on clear, level mode follows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
        end else begin
            for (int i = 0; i < NSRC; i++) begin
                if (edge_sel[i]) pending[i] <= rise[i] | (pending[i] & ~clr[i]);
                else             pending[i] <= qual[i];
            end
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_chk
        AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            edge_sel[g] && !rise[g] && !clr[g] |=> pending[g] == $past(pending[g])); // R5
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            edge_sel[g] && clr[g] && !rise[g] |=> !pending[g]); // R6
        AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            edge_sel[g] && rise[g] |=> pending[g]); // R7
    end

endmodule

// File: rtl/irqr_regfile.sv
// Register file: decodes the byte address, holds the edge, polarity and enable
// masks, turns clear writes into pulses and registers the read data.
module irqr_regfile
    import irqr_pkg::*;
#(
    parameter int NWORDS = 2,
    parameter int WORD_W = 16,
    parameter int NOUT   = 4,
    parameter int ADDR_W = 9,
    localparam int NSRC  = NWORDS * WORD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [WORD_W-1:0]         wdata,
    input  logic [NSRC-1:0]           pending,
    output logic [NSRC-1:0]           edge_sel,
    output logic [NSRC-1:0]           pol_sel,
    output logic [NSRC-1:0]           clr,
    output logic [NOUT-1:0][NSRC-1:0] en,
    output logic [WORD_W-1:0]         rdata
);

    reg_dec_t          dec;
    logic [WORD_W-1:0] rd_mux;

    // Decode the current address.
    always_comb dec = decode_addr(16'(addr), NWORDS, NOUT);

    // Hold the control masks; status is read-only and ignores writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_sel <= '0;
            pol_sel  <= '0;
            en       <= '0;
        end else if (sel && wr) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (dec.word == w) begin
                    if (dec.kind == RK_EDGE) edge_sel[w*WORD_W +: WORD_W] <= wdata;
                    if (dec.kind == RK_POL)  pol_sel[w*WORD_W +: WORD_W]  <= wdata;
                    for (int n = 0; n < NOUT; n++)
                        if (dec.kind == RK_EN && dec.out == n)
                            en[n][w*WORD_W +: WORD_W] <= wdata;
                end
            end
        end
    end

    // Turn a clear write into a one-cycle pulse on the addressed word.
    always_comb begin
        clr = '0;
        if (sel && wr && dec.kind == RK_CLEAR)
            for (int w = 0; w < NWORDS; w++)
                if (dec.word == w) clr[w*WORD_W +: WORD_W] = wdata;
    end

    // Select read data; clear and unmapped addresses read as zero.
    always_comb begin
        rd_mux = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (dec.word == w) begin
                case (dec.kind)
                    RK_STATUS: rd_mux = pending[w*WORD_W +: WORD_W];
                    RK_EDGE:   rd_mux = edge_sel[w*WORD_W +: WORD_W];
                    RK_POL:    rd_mux = pol_sel[w*WORD_W +: WORD_W];
                    RK_EN:
                        for (int n = 0; n < NOUT; n++)
                            if (dec.out == n) rd_mux = en[n][w*WORD_W +: WORD_W];
                    default:   rd_mux = '0;
                endcase
            end
        end
    end

    // Register read data one cycle after a read access.
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata <= '0;
        else if (sel && !wr) rdata <= rd_mux;
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sel && !wr && dec.kind == RK_NONE |=> rdata == '0); // R2

endmodule

// File: rtl/irqr_route.sv
// Output router: each output is the registered OR of pending sources that its
// own enable mask selects. Assumes pending and en are already synchronous.
module irqr_route #(
    parameter int NSRC = 32,
    parameter int NOUT = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           pending,
    input  logic [NOUT-1:0][NSRC-1:0] en,
    output logic [NOUT-1:0]           irq
);

    for (genvar n = 0; n < NOUT; n++) begin : g_out
        // Register the masked OR for this output.
        always_ff @(posedge clk) begin
            if (!rst_n) irq[n] <= 1'b0;
            else        irq[n] <= |(pending & en[n]);
        end

        AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            (pending & en[n]) == '0 |=> !irq[n]); // R8
        AST_IRQ_DELIVER: assert property (@(posedge clk) disable iff (!rst_n)
            (pending & en[n]) != '0 |=> irq[n]); // R9
    end

endmodule

// File: rtl/irq_route_ctrl.sv
// Top: interrupt routing controller. Joins the source front end, the register
// file and the output router. Assumes irq_src is asynchronous to clk.
module irq_route_ctrl #(
    parameter int NWORDS = 2,
    parameter int WORD_W = 16,
    parameter int NOUT   = 4,
    parameter int ADDR_W = 9,
    localparam int NSRC  = NWORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_src,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [NOUT-1:0]   cpu_irq
);

    logic [NSRC-1:0]           pending, edge_sel, pol_sel, clr;
    logic [NOUT-1:0][NSRC-1:0] en;

    irqr_sync_detect #(.NSRC(NSRC)) u_front (
        .clk(clk), .rst_n(rst_n), .src(irq_src), .edge_sel(edge_sel),
        .pol_sel(pol_sel), .clr(clr), .pending(pending)
    );

    irqr_regfile #(.NWORDS(NWORDS), .WORD_W(WORD_W), .NOUT(NOUT), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .pending(pending), .edge_sel(edge_sel), .pol_sel(pol_sel),
        .clr(clr), .en(en), .rdata(bus_rdata)
    );

    irqr_route #(.NSRC(NSRC), .NOUT(NOUT)) u_route (
        .clk(clk), .rst_n(rst_n), .pending(pending), .en(en), .irq(cpu_irq)
    );

endmodule

// File: tb/tb_irq_route_ctrl.sv
module tb_irq_route_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  cpu_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_route_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    typedef struct packed {
        logic [8:0]  a;
        logic [15:0] d;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{9'h020, 16'hA5A5}, '{9'h060, 16'h5A5A}, '{9'h030, 16'h1234}, '{9'h070, 16'hFEDC},
        '{9'h100, 16'h0001}, '{9'h110, 16'h8000}, '{9'h120, 16'h00F0}, '{9'h130, 16'h0F00},
        '{9'h140, 16'h3C3C}, '{9'h150, 16'hC3C3}, '{9'h160, 16'hFFFF}, '{9'h170, 16'h7777}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [8:0] a, logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [8:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [15:0] rd;
        // R3: reset state at the ports
        wait_cyc(3);
        check("R3 cpu_irq in reset", 32'(cpu_irq), 32'h0);
        check("R3 rdata in reset", 32'(bus_rdata), 32'h0);
        rst_n = 1'b1;
        rd_reg(9'h020, rd); check("R3 edge reset", 32'(rd), 32'h0);
        rd_reg(9'h070, rd); check("R3 polarity reset", 32'(rd), 32'h0);
        rd_reg(9'h170, rd); check("R3 enable reset", 32'(rd), 32'h0);
        // R4: default active-low level with low inputs reads pending
        wait_cyc(3);
        rd_reg(9'h000, rd); check("R4 default active-low level", 32'(rd), 32'hFFFF);

        // R1: register map walk from the vector table
        for (int i = 0; i < 12; i++) begin
            logic [15:0] got;
            wr_reg(VECS[i].a, VECS[i].d);
            rd_reg(VECS[i].a, got);
            check("R1 readback", 32'(got), 32'(VECS[i].d));
        end

        // Reconfigure: level active-high, word1 bit5 rising edge, bit4 falling edge
        wr_reg(9'h020, 16'h0000);
        wr_reg(9'h060, 16'h0030);
        wr_reg(9'h030, 16'hFFFF);
        wr_reg(9'h070, 16'hFFEF);
        for (int a = 'h100; a <= 'h170; a += 'h10) wr_reg(9'(a), 16'h0000);
        wait_cyc(4);
        wr_reg(9'h050, 16'hFFFF);
        rd_reg(9'h000, rd); check("R4 inactive level clears", 32'(rd), 32'h0);
        rd_reg(9'h040, rd); check("R6 clear word1", 32'(rd), 32'h0);

        // R4/R8: level source 3 onto output 1, exact latency
        wr_reg(9'h120, 16'h0008);
        @(negedge clk); irq_src[3] = 1'b1;
        wait_cyc(3); check("R4 latency not yet", 32'(cpu_irq), 32'h0);
        wait_cyc(1); check("R8 output 1 asserted", 32'(cpu_irq), 32'h2);
        wr_reg(9'h010, 16'h0008);
        wait_cyc(1);
        rd_reg(9'h000, rd); check("R4 clear no lasting effect", 32'(rd), 32'h0008);
        irq_src[3] = 1'b0;
        wait_cyc(5);
        check("R8 output drops", 32'(cpu_irq), 32'h0);
        rd_reg(9'h000, rd); check("R4 level follows input", 32'(rd), 32'h0);

        // R5/R9: rising edge on source 21, masked then delivered to outputs 0 and 3
        @(negedge clk); irq_src[21] = 1'b1;
        wait_cyc(2); irq_src[21] = 1'b0;
        wait_cyc(5);
        rd_reg(9'h040, rd); check("R5 rising edge latched", 32'(rd), 32'h0020);
        check("R9 masked output low", 32'(cpu_irq), 32'h0);
        wr_reg(9'h170, 16'h0020);
        wr_reg(9'h110, 16'h0020);
        wait_cyc(2); check("R8 fan-out to outputs 0 and 3", 32'(cpu_irq), 32'h9);
        wr_reg(9'h170, 16'h0000);
        wait_cyc(2); check("R9 remask output 3", 32'(cpu_irq), 32'h1);
        wr_reg(9'h110, 16'h0000);
        wait_cyc(2);
        rd_reg(9'h040, rd); check("R9 pending kept while masked", 32'(rd), 32'h0020);

        // R6: writing zero to clear has no effect
        wr_reg(9'h050, 16'h0000);
        rd_reg(9'h040, rd); check("R6 zero clear ignored", 32'(rd), 32'h0020);

        // R7: edge detected in the same cycle as a clear keeps pending
        @(negedge clk); irq_src[21] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 9'h050; bus_wdata = 16'h0020;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd_reg(9'h040, rd); check("R7 edge wins over clear", 32'(rd), 32'h0020);
        wr_reg(9'h050, 16'h0020);
        rd_reg(9'h040, rd); check("R6 clear drops pending", 32'(rd), 32'h0);

        // R5: falling-edge source 20 ignores a rise, latches a fall
        @(negedge clk); irq_src[20] = 1'b1;
        wait_cyc(5);
        rd_reg(9'h040, rd); check("R5 rise ignored in falling mode", 32'(rd), 32'h0);
        irq_src[20] = 1'b0;
        wait_cyc(5);
        rd_reg(9'h040, rd); check("R5 falling edge latched", 32'(rd), 32'h0010);
        wr_reg(9'h050, 16'h0010);

        // R2: unmapped reads and status writes
        rd_reg(9'h1F0, rd); check("R2 unmapped high", 32'(rd), 32'h0);
        rd_reg(9'h008, rd); check("R2 unaligned", 32'(rd), 32'h0);
        rd_reg(9'h180, rd); check("R2 past enables", 32'(rd), 32'h0);
        wr_reg(9'h040, 16'hFFFF);
        rd_reg(9'h040, rd); check("R2 status write ignored", 32'(rd), 32'h0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule